// File: doc/BRIEF.md
# Three-Wire Serial Register Port with Dual Channel Banks

This block is a serial slave that lets a host configure two identical channel register banks (A and B) and a small set of shared control registers. The host uses three wires: an active-low chip select, a serial clock and one data line. The data line carries the instruction and write data from the host, and it carries read data back to the host. The pad drive is split into `sdio_in`, `sdio_out` and `sdio_oe`, so the bidirectional buffer sits outside the block. All serial inputs are oversampled in the system clock domain. Data is captured on rising serial-clock edges and read data is launched on falling edges.

Every transfer has 24 bits. The first 16 bits are an instruction: a read/write flag followed by a register address. Then one data byte follows. A shared channel-select register decides which banks take a write. Its default value steers each write to both banks. A read of a bank address always returns bank A. A shared reset register holds a self-clearing software reset, which returns every register to its reset value, and a bit that pulses a reset to a downstream serial-link state machine. The bank contents drive the block outputs as flat configuration vectors.

Top module: `spi3w_regport`

## Requirements
- R1: A transfer starts when `cs_n` falls. The first 16 bits captured on rising `sclk` edges, MSB first, form the instruction. Bit 15 = 1 marks a read and 0 marks a write. Bits 14:13 are ignored. Bits 12:0 are the register address. The next 8 rising edges carry the write data byte, MSB first.
- R2: In a read, the 8 data bits of the addressed register are driven on `sdio_out`, MSB first, each launched by a falling `sclk` edge that comes after the 16th rising edge. `sdio_oe` is high only during the data phase of an active read, and it stays low throughout writes.
- R3: Raising `cs_n` aborts the transfer. A write with fewer than 24 captured bits changes no register, and `sdio_oe` is low within 4 clock cycles after `cs_n` rises.
- R4: The channel-select register at address 0x0003 uses bit 0 to enable bank A and bit 1 to enable bank B. It resets to 0b11 and reads back in bits 1:0, with the upper bits reading as 0.
- R5: A write to a bank address updates each bank whose select bit is 1. With the reset value of the select register, the write goes to both banks.
- R6: A read of a bank address returns the bank A register, whatever the value of the select register.
- R7: Writing 1 to bit 7 of the reset register at address 0x0005 restores every register to its reset value on the following cycle. The bit then clears itself, so a later read of 0x0005 returns 0x00.
- R8: Writing 1 to bit 6 of the reset register makes `link_rst` high for exactly one clock cycle, and no register changes.
- R9: A read of an unmapped address returns 0x00. A write to an unmapped address changes no register.
- R10: The bank registers occupy addresses BANK_BASE to BANK_BASE+NREG-1 and reset to 0x00. Register i appears on bits 8i+7:8i of `cfg_a` (bank A) and `cfg_b` (bank B).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data line as seen by the input buffer |
| sdio_out | output | 1 | Read data to the output buffer |
| sdio_oe | output | 1 | Output enable of the data line buffer |
| cfg_a | output | NREG*8 | Bank A register contents |
| cfg_b | output | NREG*8 | Bank B register contents |
| link_rst | output | 1 | One-cycle reset pulse to the serial-link state machine |

## Verification
The bench builds the block with NREG = 3 and BANK_BASE = 0x0010. With these values the address 0x0013, one past the last bank register, is an unmapped address next to the bank, so the boundary decode is tested at the edge of the range. Three registers are enough for each bank-select setting (A only, B only, both) to leave a different register pattern, so the final `cfg_a`/`cfg_b` comparison shows each steering decision. The serial clock runs at one sixteenth of the system clock, which leaves room for the synchronizer delay on both edges.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = 16;
  localparam int FRAME_W = INSTR_W + DATA_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam addr_t ADDR_CHAN = 13'h0003;
  localparam addr_t ADDR_RST  = 13'h0005;

  localparam logic [1:0] CHAN_RST = 2'b11;
  localparam int RST_SW_BIT   = 7;
  localparam int RST_LINK_BIT = 6;
endpackage

// File: rtl/spi3w_frontend.sv
module spi3w_frontend
  import spi3w_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  csn_i,
  input  logic  sclk_i,
  input  logic  sdi_i,
  output addr_t rd_addr_o,
  input  byte_t rd_data_i,
  output logic  wr_en_o,
  output addr_t wr_addr_o,
  output byte_t wr_data_o,
  output logic  sdo_o,
  output logic  oe_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_INSTR = CNT_W'(INSTR_W);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_W);

  logic [SYNC-1:0] sclk_sh, csn_sh, sdi_sh;
  logic            sclk_d;
  logic            sclk_s, csn_s, sdi_s, rise, fall;

  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [INSTR_W-1:0] instr_q, instr_n;
  byte_t              dsh_q, dsh_n;
  logic               ld_q, ld_n, wr_q, wr_n, oe_q, oe_n, sdo_q, sdo_n;
  logic               is_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sh <= '0;
      csn_sh  <= '1;
      sdi_sh  <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sh <= {sclk_sh[SYNC-2:0], sclk_i};
      csn_sh  <= {csn_sh[SYNC-2:0], csn_i};
      sdi_sh  <= {sdi_sh[SYNC-2:0], sdi_i};
      sclk_d  <= sclk_s;
    end
  end

  assign sclk_s  = sclk_sh[SYNC-1];
  assign csn_s   = csn_sh[SYNC-1];
  assign sdi_s   = sdi_sh[SYNC-1];
  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign is_read = instr_q[INSTR_W-1];

  always_comb begin
    cnt_n   = cnt_q;
    instr_n = instr_q;
    dsh_n   = dsh_q;
    oe_n    = oe_q;
    sdo_n   = sdo_q;
    ld_n    = 1'b0;
    wr_n    = 1'b0;
    if (csn_s) begin
      cnt_n = '0;
      oe_n  = 1'b0;
      sdo_n = 1'b0;
    end else begin
      if (rise) begin
        if (cnt_q < CNT_INSTR) begin
          instr_n = {instr_q[INSTR_W-2:0], sdi_s};
        end else if (!is_read && cnt_q <= CNT_LAST) begin
          dsh_n = {dsh_q[DATA_W-2:0], sdi_s};
        end
        if (cnt_q == CNT_INSTR - 1'b1) ld_n = 1'b1;
        if (cnt_q == CNT_LAST && !is_read) wr_n = 1'b1;
        if (cnt_q != CNT_FULL) cnt_n = cnt_q + 1'b1;
      end
      if (ld_q && is_read) dsh_n = rd_data_i;
      if (fall && is_read && cnt_q >= CNT_INSTR) begin
        oe_n  = 1'b1;
        sdo_n = dsh_q[DATA_W-1];
        dsh_n = {dsh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      instr_q <= '0;
      dsh_q   <= '0;
      ld_q    <= 1'b0;
      wr_q    <= 1'b0;
      oe_q    <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      instr_q <= instr_n;
      dsh_q   <= dsh_n;
      ld_q    <= ld_n;
      wr_q    <= wr_n;
      oe_q    <= oe_n;
      sdo_q   <= sdo_n;
    end
  end

  assign rd_addr_o = instr_q[ADDR_W-1:0];
  assign wr_addr_o = instr_q[ADDR_W-1:0];
  assign wr_data_o = dsh_q;
  assign wr_en_o   = wr_q;
  assign sdo_o     = sdo_q;
  assign oe_o      = oe_q;
endmodule

// File: rtl/spi3w_regbank.sv
module spi3w_regbank
  import spi3w_pkg::*;
#(
  parameter int    NREG      = 4,
  parameter addr_t BANK_BASE = 13'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  addr_t             wr_addr_i,
  input  byte_t             wr_data_i,
  input  addr_t             rd_addr_i,
  output byte_t             rd_data_o,
  output logic [NREG*8-1:0] cfg_a_o,
  output logic [NREG*8-1:0] cfg_b_o,
  output logic [1:0]        chan_sel_o,
  output logic              swrst_o,
  output logic              link_rst_o
);
  byte_t      a_q [NREG];
  byte_t      b_q [NREG];
  logic [1:0] chan_q, chan_n;
  logic       swrst_q, swrst_n, link_q, link_n;
  logic       wr_chan, wr_rst;

  assign wr_chan = wr_en_i && (wr_addr_i == ADDR_CHAN);
  assign wr_rst  = wr_en_i && (wr_addr_i == ADDR_RST);

  always_comb begin
    chan_n  = chan_q;
    swrst_n = 1'b0;
    link_n  = 1'b0;
    if (swrst_q) begin
      chan_n = CHAN_RST;
    end else begin
      if (wr_chan) chan_n = wr_data_i[1:0];
      if (wr_rst) begin
        swrst_n = wr_data_i[RST_SW_BIT];
        link_n  = wr_data_i[RST_LINK_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= CHAN_RST;
      swrst_q <= 1'b0;
      link_q  <= 1'b0;
    end else begin
      chan_q  <= chan_n;
      swrst_q <= swrst_n;
      link_q  <= link_n;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam addr_t REG_ADDR = BANK_BASE + addr_t'(g);
    logic  hit;
    byte_t a_n, b_n;

    assign hit = wr_en_i && (wr_addr_i == REG_ADDR);

    always_comb begin
      a_n = a_q[g];
      b_n = b_q[g];
      if (swrst_q) begin
        a_n = '0;
        b_n = '0;
      end else if (hit) begin
        if (chan_q[0]) a_n = wr_data_i;
        if (chan_q[1]) b_n = wr_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q[g] <= '0;
        b_q[g] <= '0;
      end else begin
        a_q[g] <= a_n;
        b_q[g] <= b_n;
      end
    end

    assign cfg_a_o[8*g +: 8] = a_q[g];
    assign cfg_b_o[8*g +: 8] = b_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_CHAN) begin
      rd_data_o = {6'b0, chan_q};
    end else if (rd_addr_i == ADDR_RST) begin
      rd_data_o = {swrst_q, 7'b0};
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (rd_addr_i == BANK_BASE + addr_t'(i)) rd_data_o = a_q[i];
      end
    end
  end

  assign chan_sel_o = chan_q;
  assign swrst_o    = swrst_q;
  assign link_rst_o = link_q;
endmodule

// File: rtl/spi3w_regport.sv
module spi3w_regport
  import spi3w_pkg::*;
#(
  parameter int    NREG        = 4,
  parameter addr_t BANK_BASE   = 13'h0010,
  parameter int    SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic [NREG*8-1:0] cfg_a,
  output logic [NREG*8-1:0] cfg_b,
  output logic              link_rst
);
  logic [1:0] rst_sh;
  logic       rst_ns;
  addr_t      rd_addr, wr_addr;
  byte_t      rd_data, wr_data;
  logic       wr_en;
  logic [1:0] chan_sel;
  logic       swrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ns = rst_sh[1];

  spi3w_frontend #(.SYNC(SYNC_STAGES)) i_front (
    .clk       (clk),
    .rst_n     (rst_ns),
    .csn_i     (cs_n),
    .sclk_i    (sclk),
    .sdi_i     (sdio_in),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sdo_o     (sdio_out),
    .oe_o      (sdio_oe)
  );

  spi3w_regbank #(.NREG(NREG), .BANK_BASE(BANK_BASE)) i_regs (
    .clk        (clk),
    .rst_n      (rst_ns),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .cfg_a_o    (cfg_a),
    .cfg_b_o    (cfg_b),
    .chan_sel_o (chan_sel),
    .swrst_o    (swrst),
    .link_rst_o (link_rst)
  );
endmodule

// File: rtl/spi3w_regport_chk.sv
module spi3w_regport_chk #(
  parameter int NREG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdio_oe,
  input logic              wr_en,
  input logic [1:0]        chan_sel,
  input logic              swrst,
  input logic              link_rst,
  input logic [NREG*8-1:0] cfg_a,
  input logic [NREG*8-1:0] cfg_b
);
  // R3: output released once chip select has been high long enough
  p_oe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdio_oe);

  // R5: bank B holds its value when a write arrives with its select bit clear
  p_bank_b_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chan_sel[1]) |=> $stable(cfg_b));

  // R7: software reset restores everything and clears itself
  p_swrst_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (cfg_a == '0 && cfg_b == '0 && chan_sel == 2'b11 && !swrst));

  // R8: link reset is a single-cycle pulse
  p_link_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst |=> !link_rst);
endmodule

bind spi3w_regport spi3w_regport_chk #(.NREG(NREG)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sdio_oe  (sdio_oe),
  .wr_en    (wr_en),
  .chan_sel (chan_sel),
  .swrst    (swrst),
  .link_rst (link_rst),
  .cfg_a    (cfg_a),
  .cfg_b    (cfg_b)
);

// File: tb/test_spi3w_regport.sv
`timescale 1ns/1ps
module test_spi3w_regport;
  localparam int NREG = 3;
  localparam int NV   = 16;
  localparam int HALF = 8;

  logic clk, rst_n, cs_n, sclk, sdio_in;
  logic sdio_out, sdio_oe, link_rst;
  logic [NREG*8-1:0] cfg_a, cfg_b;

  int checks = 0, fails = 0, link_cnt = 0;
  bit done = 0;

  spi3w_regport #(.NREG(NREG), .BANK_BASE(13'h0010)) i_spi3w_regport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .link_rst(link_rst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (link_rst) link_cnt++;

  // {instruction, write data, expected read data}
  localparam logic [31:0] VEC [NV] = '{
    {16'h8003, 8'h00, 8'h03},  // R4 select reset value
    {16'h0010, 8'h5A, 8'h00},  // R5 broadcast write
    {16'h8010, 8'h00, 8'h5A},  // R6
    {16'h0003, 8'h01, 8'h00},  // R4 A only
    {16'h0011, 8'hC3, 8'h00},
    {16'h8011, 8'h00, 8'hC3},
    {16'h0003, 8'h02, 8'h00},  // R4 B only
    {16'h0012, 8'h77, 8'h00},
    {16'h8012, 8'h00, 8'h00},  // R6 read comes from A
    {16'h8003, 8'h00, 8'h02},
    {16'h0013, 8'hFF, 8'h00},  // R9 unmapped write
    {16'h8013, 8'h00, 8'h00},  // R9 unmapped read
    {16'h0003, 8'h03, 8'h00},
    {16'hE010, 8'h00, 8'h5A},  // R1 reserved bits set on read
    {16'h6011, 8'h3C, 8'h00},  // R1 reserved bits set on write
    {16'h8011, 8'h00, 8'h3C}
  };
  string VTAG [NV] = '{"R4", "R5", "R6", "R4", "R5", "R1", "R4", "R5",
                       "R6", "R4", "R9", "R9", "R4", "R1", "R1", "R5"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] instr, input logic [7:0] wd, input int nbits,
                      output logic [7:0] rd, output int oe_hi);
    rd = '0;
    oe_hi = 0;
    cs_n = 1'b0;
    for (int b = 0; b < nbits; b++) begin
      sclk = 1'b0;
      sdio_in = (b < 16) ? instr[15-b] : wd[23-b];
      repeat (HALF) @(negedge clk);
      if (b >= 16) rd[23-b] = sdio_out;
      if (sdio_oe) oe_hi++;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (sdio_oe) oe_hi++;
    end
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    int oe_hi;
    cs_n = 1'b1; sclk = 1'b0; sdio_in = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 cfg_a reset", 32'(cfg_a), 32'h0);
    chk("R10 cfg_b reset", 32'(cfg_b), 32'h0);
    chk("R2 oe idle", 32'(sdio_oe), 32'h0);
    chk("R8 link idle", 32'(link_rst), 32'h0);

    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][31:16], VEC[v][15:8], 24, rd, oe_hi);
      if (VEC[v][31]) begin
        chk(VTAG[v], 32'(rd), 32'(VEC[v][7:0]));
      end else begin
        chk("R2 no drive on write", 32'(oe_hi), 32'h0);
      end
    end

    // R5 R10 resulting bank contents
    chk("R5 cfg_a", 32'(cfg_a), 32'h003C5A);
    chk("R5 cfg_b", 32'(cfg_b), 32'h773C5A);

    // R3 aborted write
    xfer(16'h0010, 8'h11, 20, rd, oe_hi);
    chk("R3 aborted write", 32'(cfg_a), 32'h003C5A);

    // R3 aborted read after data phase began
    xfer(16'h8010, 8'h00, 18, rd, oe_hi);
    chk("R2 oe during read", 32'(oe_hi > 0), 32'h1);
    chk("R3 oe released", 32'(sdio_oe), 32'h0);

    // R8 link reset pulse
    link_cnt = 0;
    xfer(16'h0005, 8'h40, 24, rd, oe_hi);
    chk("R8 link pulse count", 32'(link_cnt), 32'h1);
    chk("R8 registers kept", 32'(cfg_b), 32'h773C5A);

    // R7 software reset
    xfer(16'h0005, 8'h80, 24, rd, oe_hi);
    chk("R7 cfg_a cleared", 32'(cfg_a), 32'h0);
    chk("R7 cfg_b cleared", 32'(cfg_b), 32'h0);
    xfer(16'h8003, 8'h00, 24, rd, oe_hi);
    chk("R7 select restored", 32'(rd), 32'h03);
    xfer(16'h8005, 8'h00, 24, rd, oe_hi);
    chk("R7 reset bit cleared", 32'(rd), 32'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule